// File: doc/BRIEF.md
# DMA Channel Address and Count Generator

This block is the address and transfer-count engine of one channel in a legacy ISA-style DMA controller. Software programs a starting address, a transfer count, a page byte and a small control field through a single write port. Each transfer strobe uses the address on the output and then moves the channel one step: the low address counter goes up by one and the remaining count goes down by one.

A parameter fixes the channel as a byte channel or a word channel. A byte channel places the page byte directly above the 16-bit counter. A word channel shifts the counter left by one bit, forces address bit 0 to zero, and takes only the upper seven page bits. The page never changes when the counter rolls over.

When the count steps down past zero, the channel gives a one-cycle terminal pulse. With auto-reload on, the channel then restarts from its base values. With auto-reload off, the channel masks itself. A separate refresh address counter steps on its own strobe. Arbitration and bus timing belong to other blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset the current address, current count, page and refresh address are zero, the terminal pulse is low, auto-reload is off and the channel mask is set.
- R2: A write with select 0 loads both the base and the current address. A write with select 1 loads both the base and the current count. Select 2 loads the page.
- R3: With WORD_MODE=0 the memory address is {page[7:0], current address[15:0]}.
- R4: With WORD_MODE=1 the memory address is {page[7:1], current address[15:0], 1'b0}. Page bit 0 has no effect.
- R5: When a strobe is accepted and the count is not zero, the current address increases by one and the count decreases by one, both on the next clock edge.
- R6: When the current address wraps from 0xFFFF to 0x0000, the page does not change.
- R7: A strobe accepted while the count is 0x0000 raises the terminal pulse for exactly the next cycle.
- R8: At terminal count with auto-reload on, the current address and count reload from their base values and the mask stays clear.
- R9: At terminal count with auto-reload off, the address advances, the count becomes 0xFFFF and the mask is set. Strobes while masked change nothing.
- R10: Each refresh strobe increments the refresh address by one, modulo 2^RFSH_W.
- R11: A transfer strobe in the same cycle as any register write is ignored.
- R12: A write with select 3 sets auto-reload from data bit 0 and the channel mask from data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 address, 1 count, 2 page, 3 control |
| wr_data | input | 16 | Write data |
| xfer_stb | input | 1 | Transfer strobe |
| rfsh_stb | input | 1 | Refresh strobe |
| mem_addr_o | output | 24 | Memory address for the current transfer |
| cur_addr_o | output | 16 | Current address counter |
| cur_cnt_o | output | 16 | Current remaining count |
| tc_o | output | 1 | Terminal count pulse |
| mask_o | output | 1 | Channel mask |
| rfsh_addr_o | output | 8 | Refresh address |

## Verification
A byte instance and a word instance receive the same programmed sequence, so one run separates the two address formats and shows that page bit 0 is ignored on the word path. The sequence starts near the top of the address range. This shows in one pass that the counter wraps without touching the page and that the count passes through zero. Terminal count is reached twice, once with auto-reload off and once with it on, which separates masking from reloading. Strobes applied while masked, or together with a write, show whether an input that should be ignored is truly ignored.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_PAGE = 2'd2,
      SEL_CTRL = 2'd3
   } reg_sel_e;

   localparam int CTRL_AUTO_BIT = 0;
   localparam int CTRL_MASK_BIT = 1;
endpackage

// File: rtl/dma_ag_regs.sv
module dma_ag_regs
   import dma_ag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8,
   parameter int WR_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WR_W-1:0]   wr_data,
   input  logic              term_hit,
   output logic [ADDR_W-1:0] base_addr,
   output logic [CNT_W-1:0]  base_cnt,
   output logic [PAGE_W-1:0] page,
   output logic              auto_en,
   output logic              mask,
   output logic              ld_addr,
   output logic              ld_cnt
);
   logic ld_page, ld_ctrl;

   always_comb begin
      ld_addr = wr_en && (reg_sel_e'(wr_sel) == SEL_ADDR);
      ld_cnt  = wr_en && (reg_sel_e'(wr_sel) == SEL_CNT);
      ld_page = wr_en && (reg_sel_e'(wr_sel) == SEL_PAGE);
      ld_ctrl = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_addr <= '0;
         base_cnt  <= '0;
         page      <= '0;
         auto_en   <= 1'b0;
         mask      <= 1'b1;
      end else begin
         if (ld_addr) base_addr <= wr_data[ADDR_W-1:0];
         if (ld_cnt)  base_cnt  <= wr_data[CNT_W-1:0];
         if (ld_page) page      <= wr_data[PAGE_W-1:0];
         if (ld_ctrl) begin
            auto_en <= wr_data[CTRL_AUTO_BIT];
            mask    <= wr_data[CTRL_MASK_BIT];
         end else if (term_hit && !auto_en) begin
            mask <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_ag_counter.sv
module dma_ag_counter #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int WR_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              ld_addr,
   input  logic              ld_cnt,
   input  logic [WR_W-1:0]   wr_data,
   input  logic              auto_en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [CNT_W-1:0]  base_cnt,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [CNT_W-1:0]  cur_cnt,
   output logic              term_hit,
   output logic              tc_q
);
   localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   assign term_hit = fire && (cur_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_cnt  <= '0;
         tc_q     <= 1'b0;
      end else begin
         tc_q <= term_hit;
         if (ld_addr) begin
            cur_addr <= wr_data[ADDR_W-1:0];
         end
         if (ld_cnt) begin
            cur_cnt <= wr_data[CNT_W-1:0];
         end
         if (fire) begin
            if (term_hit && auto_en) begin
               cur_addr <= base_addr;
               cur_cnt  <= base_cnt;
            end else begin
               cur_addr <= cur_addr + ADDR_ONE;
               cur_cnt  <= cur_cnt - CNT_ONE;
            end
         end
      end
   end
endmodule

// File: rtl/dma_ag_fmt.sv
module dma_ag_fmt #(
   parameter int ADDR_W    = 16,
   parameter int PAGE_W    = 8,
   parameter int WORD_MODE = 0,
   localparam int OUT_W    = ADDR_W + PAGE_W
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [PAGE_W-1:0] page,
   output logic [OUT_W-1:0]  mem_addr
);
   generate
      if (WORD_MODE == 1) begin : g_word
         assign mem_addr = {page[PAGE_W-1:1], cur_addr, 1'b0};
      end else begin : g_byte
         assign mem_addr = {page, cur_addr};
      end
   endgenerate
endmodule

// File: rtl/dma_ag_rfsh.sv
module dma_ag_rfsh #(
   parameter int RFSH_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   output logic [RFSH_W-1:0] addr
);
   always_ff @(posedge clk) begin
      if (!rst_n)   addr <= '0;
      else if (stb) addr <= addr + RFSH_W'(1);
   end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int ADDR_W    = 16,
   parameter int CNT_W     = 16,
   parameter int PAGE_W    = 8,
   parameter int RFSH_W    = 8,
   parameter int WORD_MODE = 0,
   localparam int WR_W     = (ADDR_W > CNT_W) ? ADDR_W : CNT_W,
   localparam int OUT_W    = ADDR_W + PAGE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [WR_W-1:0]   wr_data,
   input  logic              xfer_stb,
   input  logic              rfsh_stb,
   output logic [OUT_W-1:0]  mem_addr_o,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic [CNT_W-1:0]  cur_cnt_o,
   output logic              tc_o,
   output logic              mask_o,
   output logic [RFSH_W-1:0] rfsh_addr_o
);
   generate
      if (WORD_MODE != 0 && WORD_MODE != 1) begin : g_bad_mode
         $error("WORD_MODE must be 0 or 1");
      end
      if (PAGE_W < 2 || PAGE_W > WR_W) begin : g_bad_page
         $error("PAGE_W must lie in 2..WR_W");
      end
      if (ADDR_W < 2 || CNT_W < 2 || RFSH_W < 1) begin : g_bad_width
         $error("counter widths too small");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr;
   logic [CNT_W-1:0]  base_cnt;
   logic [PAGE_W-1:0] page;
   logic              auto_en, mask, ld_addr, ld_cnt, term_hit, fire;

   assign fire = xfer_stb && !mask && !wr_en;

   dma_ag_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .WR_W(WR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .term_hit(term_hit), .base_addr(base_addr), .base_cnt(base_cnt), .page(page),
      .auto_en(auto_en), .mask(mask), .ld_addr(ld_addr), .ld_cnt(ld_cnt)
   );

   dma_ag_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WR_W(WR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .fire(fire), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
      .wr_data(wr_data), .auto_en(auto_en), .base_addr(base_addr), .base_cnt(base_cnt),
      .cur_addr(cur_addr_o), .cur_cnt(cur_cnt_o), .term_hit(term_hit), .tc_q(tc_o)
   );

   dma_ag_fmt #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_MODE(WORD_MODE)) u_fmt (
      .cur_addr(cur_addr_o), .page(page), .mem_addr(mem_addr_o)
   );

   dma_ag_rfsh #(.RFSH_W(RFSH_W)) u_rfsh (
      .clk(clk), .rst_n(rst_n), .stb(rfsh_stb), .addr(rfsh_addr_o)
   );

   assign mask_o = mask;
endmodule

// File: rtl/dma_ag_chk.sv
module dma_ag_chk #(
   parameter int ADDR_W = 16,
   parameter int CNT_W  = 16,
   parameter int PAGE_W = 8,
   parameter int RFSH_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     xfer_stb,
   input logic                     rfsh_stb,
   input logic [ADDR_W+PAGE_W-1:0] mem_addr_o,
   input logic [ADDR_W-1:0]        cur_addr_o,
   input logic [CNT_W-1:0]         cur_cnt_o,
   input logic                     tc_o,
   input logic                     mask_o,
   input logic [RFSH_W-1:0]        rfsh_addr_o
);
   localparam int OUT_W = ADDR_W + PAGE_W;

   a_r7_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
      tc_o |=> !tc_o);

   a_r7_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && !mask_o && !wr_en && cur_cnt_o == '0) |=> tc_o);

   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && !mask_o && !wr_en && cur_cnt_o != '0) |=>
      (cur_cnt_o == CNT_W'($past(cur_cnt_o) - 1'b1)) &&
      (cur_addr_o == ADDR_W'($past(cur_addr_o) + 1'b1)));

   a_r9_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_stb && mask_o && !wr_en) |=> $stable(cur_addr_o) && $stable(cur_cnt_o));

   a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mem_addr_o[OUT_W-1:ADDR_W+1]));

   a_r10_rfsh_step: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_stb |=> rfsh_addr_o == RFSH_W'($past(rfsh_addr_o) + 1'b1));

   a_r11_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && xfer_stb) |=> !tc_o);
endmodule

bind dma_addr_gen dma_ag_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W), .RFSH_W(RFSH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .xfer_stb(xfer_stb), .rfsh_stb(rfsh_stb),
   .mem_addr_o(mem_addr_o), .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o),
   .tc_o(tc_o), .mask_o(mask_o), .rfsh_addr_o(rfsh_addr_o)
);

// File: tb/sim_dma_addr_gen.sv
module sim_dma_addr_gen;
   localparam int CLK_P = 10;

   typedef struct packed {
      logic [1:0]  op;    // 0 write, 1 strobe
      logic [1:0]  sel;
      logic [15:0] data;
      logic [23:0] mem_b;
      logic [23:0] mem_w;
      logic [15:0] cnt;
      logic        tc;
      logic        mask;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 2'd3, 16'h0000, 24'h000000, 24'h000000, 16'h0000, 1'b0, 1'b0}, // R12 unmask
      '{2'd0, 2'd2, 16'h0012, 24'h120000, 24'h120000, 16'h0000, 1'b0, 1'b0}, // R2 page
      '{2'd0, 2'd0, 16'hFFFE, 24'h12FFFE, 24'h13FFFC, 16'h0000, 1'b0, 1'b0}, // R2 R3 R4
      '{2'd0, 2'd1, 16'h0002, 24'h12FFFE, 24'h13FFFC, 16'h0002, 1'b0, 1'b0}, // R2 count
      '{2'd1, 2'd0, 16'h0000, 24'h12FFFF, 24'h13FFFE, 16'h0001, 1'b0, 1'b0}, // R5
      '{2'd1, 2'd0, 16'h0000, 24'h120000, 24'h120000, 16'h0000, 1'b0, 1'b0}, // R6 wrap
      '{2'd1, 2'd0, 16'h0000, 24'h120001, 24'h120002, 16'hFFFF, 1'b1, 1'b1}, // R7 R9
      '{2'd1, 2'd0, 16'h0000, 24'h120001, 24'h120002, 16'hFFFF, 1'b0, 1'b1}, // R9 masked
      '{2'd0, 2'd3, 16'h0001, 24'h120001, 24'h120002, 16'hFFFF, 1'b0, 1'b0}, // R12 auto
      '{2'd0, 2'd0, 16'h0100, 24'h120100, 24'h120200, 16'hFFFF, 1'b0, 1'b0}, // R2
      '{2'd0, 2'd1, 16'h0001, 24'h120100, 24'h120200, 16'h0001, 1'b0, 1'b0}, // R2
      '{2'd1, 2'd0, 16'h0000, 24'h120101, 24'h120202, 16'h0000, 1'b0, 1'b0}, // R5
      '{2'd1, 2'd0, 16'h0000, 24'h120100, 24'h120200, 16'h0001, 1'b1, 1'b0}, // R8 reload
      '{2'd1, 2'd0, 16'h0000, 24'h120101, 24'h120202, 16'h0000, 1'b0, 1'b0}  // R7 R8
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [15:0] wr_data = '0;
   logic        xfer_stb = 1'b0;
   logic        rfsh_stb = 1'b0;
   logic [23:0] mem_b, mem_w;
   logic [15:0] addr_b, addr_w, cnt_b, cnt_w;
   logic        tc_b, tc_w, mask_b, mask_w;
   logic [7:0]  rf_b, rf_w;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dma_addr_gen #(.WORD_MODE(0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .xfer_stb(xfer_stb), .rfsh_stb(rfsh_stb), .mem_addr_o(mem_b), .cur_addr_o(addr_b),
      .cur_cnt_o(cnt_b), .tc_o(tc_b), .mask_o(mask_b), .rfsh_addr_o(rf_b)
   );

   dma_addr_gen #(.WORD_MODE(1)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .xfer_stb(xfer_stb), .rfsh_stb(rfsh_stb), .mem_addr_o(mem_w), .cur_addr_o(addr_w),
      .cur_cnt_o(cnt_w), .tc_o(tc_w), .mask_o(mask_w), .rfsh_addr_o(rf_w)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] d,
                      input logic xs, input logic rs);
      wr_en = we; wr_sel = sel; wr_data = d; xfer_stb = xs; rfsh_stb = rs;
      @(posedge clk);
      #1;
      wr_en = 1'b0; xfer_stb = 1'b0; rfsh_stb = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 mem", {8'h0, mem_b}, 32'h0);
      chk("R1 cnt", {16'h0, cnt_b}, 32'h0);
      chk("R1 mask", {31'h0, mask_b}, 32'h1);
      chk("R1 tc", {31'h0, tc_b}, 32'h0);
      chk("R1 rfsh", {24'h0, rf_b}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         cyc(TBL[i].op == 2'd0, TBL[i].sel, TBL[i].data, TBL[i].op == 2'd1, 1'b0);
         chk("R3 byte addr", {8'h0, mem_b}, {8'h0, TBL[i].mem_b});
         chk("R4 word addr", {8'h0, mem_w}, {8'h0, TBL[i].mem_w});
         chk("R5 count", {16'h0, cnt_b}, {16'h0, TBL[i].cnt});
         chk("R7 tc", {31'h0, tc_b}, {31'h0, TBL[i].tc});
         chk("R9 mask", {31'h0, mask_b}, {31'h0, TBL[i].mask});
      end

      // R11: strobe together with a page write is dropped; R4 page bit 0 ignored
      cyc(1'b1, 2'd2, 16'h0013, 1'b1, 1'b0);
      chk("R11 addr held", {16'h0, addr_b}, 32'h0101);
      chk("R11 cnt held", {16'h0, cnt_b}, 32'h0000);
      chk("R11 no tc", {31'h0, tc_b}, 32'h0);
      chk("R3 page byte", {8'h0, mem_b}, 32'h130101);
      chk("R4 page bit0 ignored", {8'h0, mem_w}, 32'h120202);
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      chk("R11 tc later", {31'h0, tc_b}, 32'h0);

      // R12: mask bit from control write blocks strobes
      cyc(1'b1, 2'd3, 16'h0002, 1'b0, 1'b0);
      chk("R12 mask set", {31'h0, mask_b}, 32'h1);
      cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0);
      chk("R12 masked addr", {16'h0, addr_b}, 32'h0101);
      chk("R12 masked cnt", {16'h0, cnt_b}, 32'h0000);
      chk("R12 masked tc", {31'h0, tc_b}, 32'h0);

      // R10: refresh counter wraps modulo 256
      for (int k = 0; k < 300; k++) cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R10 rfsh wrap", {24'h0, rf_b}, 32'd44);
      chk("R10 rfsh word inst", {24'h0, rf_w}, 32'd44);

      // R1 again: reset clears a dirty channel
      rst_n = 1'b0;
      @(posedge clk);
      #1 rst_n = 1'b1;
      chk("R1 reset mem", {8'h0, mem_b}, 32'h0);
      chk("R1 reset mask", {31'h0, mask_b}, 32'h1);
      chk("R1 reset rfsh", {24'h0, rf_b}, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule